// File: doc/BRIEF.md
# Memory-Mapped I/O Bus Controller

This block is the bus controller of a 16-bit, byte-addressable machine. On each cycle the control unit presents an access: an enable, a read/write flag, a size flag and an address. The controller decides whether the access goes to the byte-wide memory pair or to one of the device registers at the top of the address space. It raises the per-byte write enables for the two memory halves and picks the source that feeds the data register's read mux.

Three device registers live inside the block: keyboard status, display status and display data. Each is 16 bits wide and is loaded from the write data on the clock edge that ends a matching write. The keyboard data word comes in from outside and can only be read. Byte reads return one sign-extended half of the selected word. The address parity picks which half.

Top module: `io_bus_ctrl`

## Requirements
- R1: After reset the keyboard status, display status and display data registers all read 0x0000.
- R2: While `mio_en` is 0, `mem_en`, `we_lo` and `we_hi` are 0 and no device register changes on the next edge, whatever the other inputs are.
- R3: With `mio_en` at 1, `mem_en` is 0 for the addresses 0xFE00, 0xFE02, 0xFE04 and 0xFE06 and 1 for every other address, for reads and writes alike.
- R4: A write (`wr`=1) to 0xFE00, 0xFE04 or 0xFE06 loads `wdata` into keyboard status, display status or display data on the next rising edge. A write to 0xFE02 and any read leave all three registers unchanged.
- R5: A word read of 0xFE00 returns keyboard status, of 0xFE02 returns `kb_data`, and of 0xFE04 returns display status, on `rdata` in the same cycle.
- R6: A word read of 0xFE06 returns 0x0000 on `rdata`.
- R7: A word read of any non-device address returns `mem_rdata` unchanged on `rdata` in the same cycle.
- R8: `we_lo` is 1 exactly when `mio_en`=1, `wr`=1 and address bit 0 is 0, for both sizes (`word`=0 byte, `word`=1 word).
- R9: `we_hi` is 1 exactly when `mio_en`=1, `wr`=1 and (address bit 0 XOR `word`) is 1. An odd-address word write raises neither lane enable.
- R10: A byte read (`word`=0) returns bits 7:0 of the selected source when address bit 0 is 0, and bits 15:8 when it is 1, sign-extended from bit 7 of that byte to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mio_en | input | 1 | Access enable from the control unit |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = word access, 0 = byte access |
| addr | input | 16 | Address register contents |
| wdata | input | 16 | Write data from the data register |
| mem_rdata | input | 16 | Read data from the memory pair |
| kb_data | input | 16 | Keyboard data word |
| mem_en | output | 1 | Memory access enable |
| we_lo | output | 1 | Write enable, low-byte memory half |
| we_hi | output | 1 | Write enable, high-byte memory half |
| rdata | output | 16 | Selected and formatted read data |
| kbsr | output | 16 | Keyboard status register |
| dsr | output | 16 | Display status register |
| ddr | output | 16 | Display data register |

## Verification
`mem_en`, both lane enables and `rdata` are combinational, so they are due in the same cycle as the access. The register outputs change one rising edge after a load. The driver applies each access on a falling edge and queues the expected enables and read data together with the register values the model holds before that access. The monitor compares the queue entry 3 ns after the same falling edge, before the next rising edge, so a write's effect is seen in the entry of the following access.

// File: rtl/io_bus_pkg.sv
package io_bus_pkg;

    // Read source picked by the address decoder
    typedef enum logic [2:0] {
        SRC_MEM    = 3'd0,
        SRC_KBSR   = 3'd1,
        SRC_KBDATA = 3'd2,
        SRC_DSR    = 3'd3,
        SRC_NONE   = 3'd4
    } rd_src_e;

    // Register file state
    typedef struct packed {
        logic [15:0] kbsr;
        logic [15:0] dsr;
        logic [15:0] ddr;
    } dev_regs_t;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import io_bus_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] KBSR_ADDR   = 16'hFE00,
    parameter logic [AW-1:0] KBDATA_ADDR = 16'hFE02,
    parameter logic [AW-1:0] DSR_ADDR    = 16'hFE04,
    parameter logic [AW-1:0] DDR_ADDR    = 16'hFE06
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mio_en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          mem_en,
    output logic          ld_kbsr,
    output logic          ld_dsr,
    output logic          ld_ddr,
    output rd_src_e       rd_src
);

    logic hit_kbsr, hit_kbdata, hit_dsr, hit_ddr, hit_dev;

    always_comb begin
        hit_kbsr   = (addr == KBSR_ADDR);
        hit_kbdata = (addr == KBDATA_ADDR);
        hit_dsr    = (addr == DSR_ADDR);
        hit_ddr    = (addr == DDR_ADDR);
        hit_dev    = hit_kbsr | hit_kbdata | hit_dsr | hit_ddr;

        mem_en  = mio_en & ~hit_dev;
        ld_kbsr = mio_en & wr & hit_kbsr;
        ld_dsr  = mio_en & wr & hit_dsr;
        ld_ddr  = mio_en & wr & hit_ddr;

        if (!hit_dev)        rd_src = SRC_MEM;
        else if (hit_kbsr)   rd_src = SRC_KBSR;
        else if (hit_kbdata) rd_src = SRC_KBDATA;
        else if (hit_dsr)    rd_src = SRC_DSR;
        else                 rd_src = SRC_NONE;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mio_en |-> (!mem_en && !ld_kbsr && !ld_dsr && !ld_ddr));

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_kbsr, ld_dsr, ld_ddr}));

    // R3
    load_not_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kbsr || ld_dsr || ld_ddr) |-> (wr && !mem_en));

    // R3
    mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (rd_src == SRC_MEM));

endmodule

// File: rtl/io_lane_enable.sv
module io_lane_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic mio_en,
    input  logic wr,
    input  logic word,
    input  logic addr0,
    output logic we_lo,
    output logic we_hi
);

    logic wr_act;

    always_comb begin
        wr_act = mio_en & wr;
        we_lo  = wr_act & ~addr0;
        we_hi  = wr_act & (addr0 ^ word);
    end

    // R9
    odd_word_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr0 && word) |-> (!we_lo && !we_hi));

    // R8
    lo_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |-> (!addr0 && wr && mio_en));

    // R9
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word |-> !(we_lo && we_hi));

endmodule

// File: rtl/io_dev_regs.sv
module io_dev_regs
    import io_bus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_kbsr,
    input  logic          ld_dsr,
    input  logic          ld_ddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] kbsr,
    output logic [DW-1:0] dsr,
    output logic [DW-1:0] ddr
);

    typedef struct packed {
        logic [DW-1:0] kbsr;
        logic [DW-1:0] dsr;
        logic [DW-1:0] ddr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (ld_kbsr) regs_d.kbsr = wdata;
        if (ld_dsr)  regs_d.dsr  = wdata;
        if (ld_ddr)  regs_d.ddr  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign kbsr = regs_q.kbsr;
    assign dsr  = regs_q.dsr;
    assign ddr  = regs_q.ddr;

    // R4
    kbsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_kbsr |=> (kbsr == $past(wdata)));

    // R4
    ddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ddr |=> (ddr == $past(wdata)));

    // R4
    dsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_dsr |=> $stable(dsr));

endmodule

// File: rtl/io_read_format.sv
module io_read_format
    import io_bus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word,
    input  logic          addr0,
    input  rd_src_e       rd_src,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] kbsr,
    input  logic [DW-1:0] kb_data,
    input  logic [DW-1:0] dsr,
    output logic [DW-1:0] rdata
);

    localparam int HALF = DW / 2;

    logic [DW-1:0]   src_word;
    logic [HALF-1:0] src_byte;

    always_comb begin
        unique case (rd_src)
            SRC_MEM:    src_word = mem_rdata;
            SRC_KBSR:   src_word = kbsr;
            SRC_KBDATA: src_word = kb_data;
            SRC_DSR:    src_word = dsr;
            default:    src_word = '0;
        endcase
        src_byte = addr0 ? src_word[DW-1:HALF] : src_word[HALF-1:0];
        if (word) rdata = src_word;
        else      rdata = {{HALF{src_byte[HALF-1]}}, src_byte};
    end

    // R10
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word |-> (rdata[DW-1:HALF] == {HALF{rdata[HALF-1]}}));

    // R6
    blank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word && rd_src == SRC_NONE) |-> (rdata == '0));

    // R7
    mem_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word && rd_src == SRC_MEM) |-> (rdata == mem_rdata));

endmodule

// File: rtl/io_bus_ctrl.sv
module io_bus_ctrl
    import io_bus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter logic [AW-1:0] KBSR_ADDR   = 16'hFE00,
    parameter logic [AW-1:0] KBDATA_ADDR = 16'hFE02,
    parameter logic [AW-1:0] DSR_ADDR    = 16'hFE04,
    parameter logic [AW-1:0] DDR_ADDR    = 16'hFE06
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mio_en,
    input  logic          wr,
    input  logic          word,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] kb_data,
    output logic          mem_en,
    output logic          we_lo,
    output logic          we_hi,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] kbsr,
    output logic [DW-1:0] dsr,
    output logic [DW-1:0] ddr
);

    logic    ld_kbsr, ld_dsr, ld_ddr;
    rd_src_e rd_src;

    io_addr_decode #(
        .AW(AW), .KBSR_ADDR(KBSR_ADDR), .KBDATA_ADDR(KBDATA_ADDR),
        .DSR_ADDR(DSR_ADDR), .DDR_ADDR(DDR_ADDR)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .mio_en(mio_en), .wr(wr), .addr(addr),
        .mem_en(mem_en), .ld_kbsr(ld_kbsr), .ld_dsr(ld_dsr),
        .ld_ddr(ld_ddr), .rd_src(rd_src)
    );

    io_lane_enable u_lanes (
        .clk(clk), .rst_n(rst_n), .mio_en(mio_en), .wr(wr), .word(word),
        .addr0(addr[0]), .we_lo(we_lo), .we_hi(we_hi)
    );

    io_dev_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_kbsr(ld_kbsr), .ld_dsr(ld_dsr),
        .ld_ddr(ld_ddr), .wdata(wdata), .kbsr(kbsr), .dsr(dsr), .ddr(ddr)
    );

    io_read_format #(.DW(DW)) u_rfmt (
        .clk(clk), .rst_n(rst_n), .word(word), .addr0(addr[0]),
        .rd_src(rd_src), .mem_rdata(mem_rdata), .kbsr(kbsr),
        .kb_data(kb_data), .dsr(dsr), .rdata(rdata)
    );

    // R2
    lanes_need_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo || we_hi) |-> mio_en);

endmodule

// File: tb/io_bus_ctrl_tb.sv
module io_bus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mio_en = 1'b0, wr = 1'b0, word = 1'b1;
    logic [15:0] addr = '0, wdata = '0, mem_rdata = '0, kb_data = '0;
    logic        mem_en, we_lo, we_hi;
    logic [15:0] rdata, kbsr, dsr, ddr;

    always #5 clk = ~clk;

    io_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mio_en(mio_en), .wr(wr), .word(word),
        .addr(addr), .wdata(wdata), .mem_rdata(mem_rdata), .kb_data(kb_data),
        .mem_en(mem_en), .we_lo(we_lo), .we_hi(we_hi), .rdata(rdata),
        .kbsr(kbsr), .dsr(dsr), .ddr(ddr)
    );

    typedef struct {
        logic        e_mem, e_lo, e_hi, chk_rd;
        logic [15:0] e_rd, e_kbsr, e_dsr, e_ddr;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [15:0] m_kbsr = '0, m_dsr = '0, m_ddr = '0;
    bit          done = 0;

    function automatic logic [15:0] fmt(input logic [15:0] w, input logic sz, input logic a0);
        logic [7:0] b;
        b = a0 ? w[15:8] : w[7:0];
        return sz ? w : {{8{b[7]}}, b};
    endfunction

    task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic m, input logic w, input logic sz, input logic [15:0] a,
                          input logic [15:0] wd, input logic [15:0] mr, input logic [15:0] kd,
                          input string req);
        item_t it;
        logic  dev;
        logic [15:0] src;
        @(negedge clk);
        mio_en = m; wr = w; word = sz; addr = a; wdata = wd; mem_rdata = mr; kb_data = kd;
        dev = (a == 16'hFE00) || (a == 16'hFE02) || (a == 16'hFE04) || (a == 16'hFE06);
        case (a)
            16'hFE00: src = m_kbsr;
            16'hFE02: src = kd;
            16'hFE04: src = m_dsr;
            16'hFE06: src = 16'h0000;
            default:  src = mr;
        endcase
        it.e_mem  = m & ~dev;
        it.e_lo   = m & w & ~a[0];
        it.e_hi   = m & w & (a[0] ^ sz);
        it.chk_rd = m & ~w;
        it.e_rd   = fmt(src, sz, a[0]);
        it.e_kbsr = m_kbsr; it.e_dsr = m_dsr; it.e_ddr = m_ddr;
        it.req    = req;
        sb_q.push_back(it);
        if (m && w) begin
            if (a == 16'hFE00) m_kbsr = wd;
            if (a == 16'hFE04) m_dsr  = wd;
            if (a == 16'hFE06) m_ddr  = wd;
        end
    endtask

    // monitor: 3 ns after each falling edge, before the next rising edge
    always @(negedge clk) begin
        item_t it;
        #3;
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            cmp(it.req, "mem_en", {15'd0, mem_en}, {15'd0, it.e_mem});
            cmp(it.req, "we_lo",  {15'd0, we_lo},  {15'd0, it.e_lo});
            cmp(it.req, "we_hi",  {15'd0, we_hi},  {15'd0, it.e_hi});
            if (it.chk_rd) cmp(it.req, "rdata", rdata, it.e_rd);
            cmp(it.req, "kbsr", kbsr, it.e_kbsr);
            cmp(it.req, "dsr",  dsr,  it.e_dsr);
            cmp(it.req, "ddr",  ddr,  it.e_ddr);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset values
        access(0, 0, 1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R1");
        // R2 disabled write to a device address
        access(0, 1, 1, 16'hFE00, 16'hAAAA, 16'h0000, 16'h0000, "R2");
        access(0, 1, 0, 16'h4000, 16'hAAAA, 16'h0000, 16'h0000, "R2");
        // R4 device writes
        access(1, 1, 1, 16'hFE00, 16'h8001, 16'h0000, 16'h0000, "R4");
        access(1, 1, 1, 16'hFE04, 16'h00C3, 16'h0000, 16'h0000, "R4");
        access(1, 1, 1, 16'hFE06, 16'h1234, 16'h0000, 16'h0000, "R4");
        access(1, 1, 1, 16'hFE02, 16'h5555, 16'h0000, 16'h0000, "R4");
        // R5 device reads
        access(1, 0, 1, 16'hFE00, 16'h9999, 16'h7777, 16'h0041, "R5");
        access(1, 0, 1, 16'hFE02, 16'h9999, 16'h7777, 16'h0041, "R5");
        access(1, 0, 1, 16'hFE04, 16'h9999, 16'h7777, 16'h0041, "R5");
        // R6 unsourced read, R3 memory stays off
        access(1, 0, 1, 16'hFE06, 16'h0000, 16'hFFFF, 16'h0041, "R6");
        // R7 memory reads
        access(1, 0, 1, 16'h3000, 16'h0000, 16'hBEEF, 16'h0000, "R7");
        access(1, 0, 1, 16'hFE08, 16'h0000, 16'h1357, 16'h0000, "R7");
        access(1, 0, 1, 16'hFDFE, 16'h0000, 16'h2468, 16'h0000, "R3");
        // R8 / R9 lane enables
        access(1, 1, 0, 16'h4000, 16'h00AB, 16'h0000, 16'h0000, "R8");
        access(1, 1, 0, 16'h4001, 16'hAB00, 16'h0000, 16'h0000, "R9");
        access(1, 1, 1, 16'h4000, 16'hCAFE, 16'h0000, 16'h0000, "R8");
        access(1, 1, 1, 16'h4001, 16'hCAFE, 16'h0000, 16'h0000, "R9");
        access(1, 1, 1, 16'hFE01, 16'hCAFE, 16'h0000, 16'h0000, "R3");
        // R10 byte reads
        access(1, 0, 0, 16'h3000, 16'h0000, 16'h12F0, 16'h0000, "R10");
        access(1, 0, 0, 16'h3001, 16'h0000, 16'h12F0, 16'h0000, "R10");
        access(1, 0, 0, 16'h3001, 16'h0000, 16'h8077, 16'h0000, "R10");
        access(1, 0, 0, 16'hFE00, 16'h0000, 16'h0000, 16'h0000, "R10");
        access(1, 0, 0, 16'hFE04, 16'h0000, 16'h0000, 16'h0000, "R10");
        // R4 reads and a second kbsr load
        access(1, 1, 1, 16'hFE00, 16'h0F0F, 16'h0000, 16'h0000, "R4");
        access(0, 1, 1, 16'hFE06, 16'hDEAD, 16'h0000, 16'h0000, "R2");
        access(1, 0, 1, 16'hFE00, 16'h0000, 16'h0000, 16'h0000, "R5");
        access(0, 0, 1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R4");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule